// File: doc/BRIEF.md
# Decimation Chain Timing Controller

This block produces the timing strobes for a three-stage cascaded decimation path that follows a sigma-delta modulator. It runs on the master clock. From that clock it builds a modulator-rate enable at half the master rate, and from the enable it builds one strobe per decimation stage. The first stage divides by 4. The second stage divides by 8, 16 or 32, chosen by a rate code. The third stage divides by 2. The overall ratio from modulator rate to output data rate is therefore 64, 128 or 256.

A data-ready pulse marks each output word at the final rate. A settled flag tells downstream logic when the filter history is valid. The flag rises a fixed, rate-dependent number of master clock cycles after the last sync request or reset. The rate code is captured only at sync (or reset), so the timing never changes in the middle of a run. The filter arithmetic itself sits outside this block and is driven by these strobes.

Top module: `decim_timing`

## Requirements
- R1: `mod_en` is low in the first master clock cycle after a sync or reset edge, high in the second, and from then on alternates every cycle.
- R2: `s1_stb` is high for one cycle on every 4th `mod_en` cycle, so it is high exactly in cycles k after sync where (k+1) is a multiple of 8, and only when `mod_en` is high.
- R3: `s2_stb` is high on every N2-th `s1_stb`, where N2 is 8, 16 or 32 for latched rate codes 00, 01 and 10. It is high in cycles k where (k+1) is a multiple of 8·N2.
- R4: `drdy` is a one-cycle pulse on every 2nd `s2_stb`. It first occurs in cycle 16·N2−1 after sync and then repeats every 16·N2 master cycles, which is 128, 256 or 512 cycles for overall decimation 64, 128 or 256.
- R5: `settled` is low through cycle L−1 and high from cycle L on, counted from the sync edge (cycle 0). L is 7122 for code 00, 14217 for code 01, and 27895 for code 10.
- R6: Once high, `settled` stays high until the next sync or reset. `drdy` pulses continue whether or not `settled` is high.
- R7: A change of `rate_sel` without a sync has no effect on strobe spacing or settle time. The code latched at the last sync or reset stays in force.
- R8: A one-cycle `sync_req` clears all stage counters and `settled`, and restarts the settle count. A sync that arrives in the same cycle as a `drdy` pulse takes priority and restarts the timing. The synchronous, active-high `rst` does the same and also latches the rate code.
- R9: Rate code 11 behaves exactly as code 00, giving decimation 64 and L = 7122.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | One-cycle restart request; latches `rate_sel` |
| rate_sel | input | 2 | Overall decimation code: 00=64, 01=128, 10=256, 11=64 |
| mod_en | output | 1 | Modulator-rate enable, every second master cycle |
| s1_stb | output | 1 | First-stage (divide by 4) output strobe |
| s2_stb | output | 1 | Second-stage (selectable) output strobe |
| drdy | output | 1 | Data-ready pulse at the output data rate |
| settled | output | 1 | Filter-settled flag |

## Verification
Two functions can fall in the same cycle: a sync request and a data-ready pulse. The bench provokes this by asserting `sync_req` in exactly the cycle where each run's last expected `drdy` is high. That pulse must still be seen and scored. After that edge, the cycle count, `mod_en` and `settled` must all restart, and no stray strobe may appear at the old phase. The scoreboard judges each following run from a fresh cycle zero. A late-settling rate is also followed at once by a fast rate, so that a stale settle count or phase would show up as a mismatch in pulse times.

// File: rtl/decim_timing.sv
module decim_timing #(
  parameter int S1_RATIO    = 4,
  parameter int S3_RATIO    = 2,
  parameter int SETTLE_D64  = 7122,
  parameter int SETTLE_D128 = 14217,
  parameter int SETTLE_D256 = 27895
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_req,
  input  logic [1:0] rate_sel,
  output logic       mod_en,
  output logic       s1_stb,
  output logic       s2_stb,
  output logic       drdy,
  output logic       settled
);
  localparam int CW  = $clog2(SETTLE_D256 + 1);
  localparam int C1W = (S1_RATIO > 2) ? $clog2(S1_RATIO) : 1;
  localparam int C3W = (S3_RATIO > 2) ? $clog2(S3_RATIO) : 1;
  localparam int C2W = 6;

  logic           restart;
  logic [1:0]     rate_q;
  logic           ph;
  logic [C1W-1:0] c1;
  logic [C2W-1:0] c2, n2;
  logic [C3W-1:0] c3;
  logic [CW-1:0]  scnt, limit;

  assign restart = rst | sync_req;

  always_ff @(posedge clk)
    if (restart) rate_q <= (rate_sel == 2'b11) ? 2'b00 : rate_sel;

  always_comb begin
    case (rate_q)
      2'b01:   begin n2 = C2W'(16); limit = CW'(SETTLE_D128); end
      2'b10:   begin n2 = C2W'(32); limit = CW'(SETTLE_D256); end
      default: begin n2 = C2W'(8);  limit = CW'(SETTLE_D64);  end
    endcase
  end

  assign mod_en  = ph;
  assign s1_stb  = mod_en && (c1 == C1W'(S1_RATIO - 1));
  assign s2_stb  = s1_stb && (c2 == n2 - C2W'(1));
  assign drdy    = s2_stb && (c3 == C3W'(S3_RATIO - 1));
  assign settled = (scnt == limit);

  always_ff @(posedge clk) begin
    if (restart) begin
      ph   <= 1'b0;
      c1   <= '0;
      c2   <= '0;
      c3   <= '0;
      scnt <= '0;
    end else begin
      ph <= ~ph;
      if (mod_en) c1 <= s1_stb ? '0 : c1 + C1W'(1);
      if (s1_stb) c2 <= s2_stb ? '0 : c2 + C2W'(1);
      if (s2_stb) c3 <= drdy ? '0 : c3 + C3W'(1);
      if (!settled) scnt <= scnt + CW'(1);
    end
  end

  p_enable_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !sync_req) |=> !mod_en);
  p_stage1_on_enable_r2: assert property (@(posedge clk) disable iff (rst)
    s1_stb |-> mod_en);
  p_stage2_on_stage1_r3: assert property (@(posedge clk) disable iff (rst)
    s2_stb |-> s1_stb);
  p_ready_on_stage2_r4: assert property (@(posedge clk) disable iff (rst)
    drdy |-> s2_stb);
  p_ready_single_r4: assert property (@(posedge clk) disable iff (rst)
    drdy |=> !drdy);
  p_settled_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (settled && !sync_req) |=> settled);
  p_rate_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !sync_req |=> $stable(rate_q));
  p_sync_clears_r8: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> (!settled && !mod_en && !s1_stb && !drdy));
endmodule

// File: tb/test_decim_timing.sv
module test_decim_timing;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, sync_req = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic mod_en, s1_stb, s2_stb, drdy, settled;

  int checks = 0, errors = 0;
  int cyc = 0;
  int cur_n2 = 8;
  int exp_q[$];
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  decim_timing i_decim_timing (
    .clk(clk), .rst(rst), .sync_req(sync_req), .rate_sel(rate_sel),
    .mod_en(mod_en), .s1_stb(s1_stb), .s2_stb(s2_stb), .drdy(drdy), .settled(settled));

  always @(posedge clk) cyc <= (rst || sync_req) ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cyc %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // monitor: compares strobes against the expected schedule
  always @(negedge clk) if (!rst && !done) begin
    bit e1, e2, e0;
    e0 = (cyc % 2) == 1;
    e1 = ((cyc + 1) % 8) == 0;
    e2 = ((cyc + 1) % (8 * cur_n2)) == 0;
    if (mod_en || e0) chk(mod_en == e0, "R1 mod_en", mod_en, e0);
    if (s1_stb || e1) chk(s1_stb == e1, "R2 s1_stb", s1_stb, e1);
    if (s2_stb || e2) chk(s2_stb == e2, "R3 s2_stb", s2_stb, e2);
    if (drdy) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected drdy", cyc, -1);
      else begin
        int t;
        t = exp_q.pop_front();
        chk(cyc == t, "R4 drdy time", cyc, t);
      end
    end
  end

  // driver: called at a negedge; pulses sync, pushes expected drdy times,
  // checks settle edges, and ends at the last drdy cycle
  task automatic run(input logic [1:0] sel, input logic [1:0] late_sel, input bit change);
    int n2, lim, per, nd;
    n2  = (sel == 2'b01) ? 16 : (sel == 2'b10) ? 32 : 8;
    lim = (sel == 2'b01) ? 14217 : (sel == 2'b10) ? 27895 : 7122;
    per = 16 * n2;
    nd  = lim / per + 1;
    rate_sel = sel;
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    chk(exp_q.size() == 0, "R8 leftover drdy", exp_q.size(), 0);
    exp_q.delete();
    cur_n2 = n2;
    for (int m = 1; m <= nd; m++) exp_q.push_back(per * m - 1);
    chk(cyc == 0, "R8 restart count", cyc, 0);
    chk(settled == 1'b0, "R8 settled cleared", settled, 0);
    chk(mod_en == 1'b0, "R1 first cycle low", mod_en, 0);
    if (change) rate_sel = late_sel;
    while (cyc < per * nd - 1) begin
      @(negedge clk);
      if (cyc == lim - 1) chk(settled == 1'b0, "R5 settled early", settled, 0);
      if (cyc == lim)     chk(settled == 1'b1, "R5 settled on time", settled, 1);
      if (cyc > lim && (cyc % per) == per - 1)
        chk(settled == 1'b1, "R6 settled held at drdy", settled, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mod_en == 1'b0 && drdy == 1'b0, "R8 reset outputs", {mod_en, drdy}, 0);
    chk(settled == 1'b0, "R8 reset settled", settled, 0);
    rst = 1'b0;
    run(2'b00, 2'b00, 1'b0);
    run(2'b10, 2'b00, 1'b0);
    run(2'b01, 2'b00, 1'b0);
    run(2'b11, 2'b10, 1'b1);  // R9 code 11 as 64; R7 late change to 10 ignored
    run(2'b00, 2'b01, 1'b1);  // R7 late change to 01 ignored
    @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 missing drdy", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog at cyc %0d: actual=hung expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule